// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Receiver

This block recovers the reply of a passive tag on the reader side of a contactless link. The reply has no start marker, no stop marker and no length field. The reader must therefore know in advance how many bits it expects, and it times the whole reply from one reference point. That reference is the `start` strobe, which the transmitter issues when it finishes its own frame. After `start`, the block waits a fixed turnaround of ticks. It then divides time into back-to-back bit windows of equal length.

Inside each window the block counts the transitions of the thresholded receive level. The level first passes through a two-flop synchroniser. A tag sending a 1 modulates a subcarrier, which gives many transitions per window. A tag sending a 0 gives few or none. The bit is decided from the count, not from any single sample of the level. A reply made only of zeros looks the same as an empty field, so the block reports no presence indication.

The result is a plain strobe with held data, not a stream. `done` pulses for one cycle, and `rx_data` and `rx_nbits` keep their values until the next `start`. No ready signal exists and no back-pressure applies, because a consumer can read the result at any time before it starts the next reply.

Top module: `edge_count_rx`

## Requirements
- R1: After reset, `done` is 0, `rx_data` is 0 and `rx_nbits` is 0.
- R2: Ticks are the cycles in which `tick_en` is 1. Window 0 closes on the tick numbered 490+150 counted from `start`. Window i closes 150 ticks after window i-1, with no gap between windows. For a reply of N bits, `done` is high in the cycle after the clock edge that carries tick 490+150·N.
- R3: A window whose count of synchronised level transitions is strictly greater than 20 and strictly less than 60 decodes as 1. Every other count decodes as 0. This includes 0, 20, 60 and counts far above 60.
- R4: The bit from window i is placed in `rx_data[i]`, so the first bit is the LSB. Every bit at position `rx_nbits` or above reads 0.
- R5: A requested length above 16 is treated as 16. `rx_nbits` reports the length after this limit.
- R6: A `start` with a requested length of 0 raises `done` in the next cycle, with `rx_data` = 0 and `rx_nbits` = 0.
- R7: `done` stays high for exactly one cycle. After it, `rx_data` and `rx_nbits` hold steady and changes on `rx_level` have no effect until the next `start`.
- R8: A `start` that arrives during a reply abandons that reply, which then never produces `done`. It also restarts the turnaround from the new `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle time-base tick |
| rx_level | input | 1 | Thresholded receive level, asynchronous |
| start | input | 1 | End of the reader frame; starts a new reply timeline |
| req_bits | input | REQ_W (6) | Expected reply length in bits |
| rx_data | output | MAX_BITS (16) | Received bits, LSB first |
| rx_nbits | output | CNT_W (5) | Reply length after the limit is applied |
| done | output | 1 | One-cycle strobe when the reply is complete |

## Verification
If the tick counter holds a wrong value, the whole reply moves in time. This shows first as `done` arriving on the wrong cycle, up to 490+150·N ticks after `start`. It may also show as a bit taken from its neighbour's window. If the edge counter is not cleared or saturates wrongly, only the affected bits are wrong, and they appear in `rx_data` when `done` rises. A stuck bit index or a wrong length latch shows at the same `done` as bits in the wrong positions or a wrong `rx_nbits`. The bench drives transition counts that sit on both sides of each decision threshold and checks the cycle of every `done`, so each of these faults is caught at the end of the reply in which it occurs.

// File: rtl/ecr_pkg.sv
package ecr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_TURN = 2'd1,
    PH_BITS = 2'd2
  } rx_phase_e;
endpackage

// File: rtl/ecr_sync.sv
module ecr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic toggle
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], din};
      last_q <= chain[STAGES-1];
    end
  end

  assign level  = chain[STAGES-1];
  assign toggle = level ^ last_q;
endmodule

// File: rtl/ecr_tick_timer.sv
module ecr_tick_timer #(
  parameter int TURN_TICKS = 490,
  parameter int WIN_TICKS  = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick_en,
  input  logic in_bits,
  output logic wrap
);
  localparam int MAXT = (TURN_TICKS > WIN_TICKS) ? TURN_TICKS : WIN_TICKS;
  localparam int TW   = $clog2(MAXT);

  logic [TW-1:0] tc_q;
  logic [TW-1:0] limit_m1;

  assign limit_m1 = in_bits ? TW'(WIN_TICKS - 1) : TW'(TURN_TICKS - 1);
  assign wrap     = run && tick_en && (tc_q == limit_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q <= '0;
    end else if (clr) begin
      tc_q <= '0;
    end else if (run && tick_en) begin
      tc_q <= wrap ? '0 : tc_q + 1'b1;
    end
  end
endmodule

// File: rtl/ecr_edge_win.sv
module ecr_edge_win #(
  parameter int EDGE_LO = 20,
  parameter int EDGE_HI = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic count_en,
  input  logic toggle,
  input  logic close,
  output logic bit_val
);
  localparam int CW = $clog2(EDGE_HI + 1);

  logic [CW-1:0] ec_q;
  logic [CW-1:0] ec_next;

  always_comb begin
    ec_next = ec_q;
    if (count_en && toggle && (ec_q != CW'(EDGE_HI))) begin
      ec_next = ec_q + 1'b1;
    end
  end

  assign bit_val = (ec_next > CW'(EDGE_LO)) && (ec_next < CW'(EDGE_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ec_q <= '0;
    end else if (clr || close) begin
      ec_q <= '0;
    end else begin
      ec_q <= ec_next;
    end
  end
endmodule

// File: rtl/edge_count_rx.sv
module edge_count_rx #(
  parameter int TURN_TICKS  = 490,
  parameter int WIN_TICKS   = 150,
  parameter int EDGE_LO     = 20,
  parameter int EDGE_HI     = 60,
  parameter int MAX_BITS    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int REQ_W       = 6,
  localparam int CNT_W      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                rx_level,
  input  logic                start,
  input  logic [REQ_W-1:0]    req_bits,
  output logic [MAX_BITS-1:0] rx_data,
  output logic [CNT_W-1:0]    rx_nbits,
  output logic                done
);
  import ecr_pkg::*;

  localparam int IDX_W = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

  rx_phase_e           phase_q;
  logic [IDX_W-1:0]    idx_q;
  logic [CNT_W-1:0]    need_q;
  logic [MAX_BITS-1:0] shreg_q;
  logic [MAX_BITS-1:0] word_now;
  logic [CNT_W-1:0]    req_len;
  logic                lvl_sync;
  logic                edge_seen;
  logic                wrap;
  logic                win_close;
  logic                bit_val;
  logic                last_bit;

  // limit the requested length
  assign req_len = (req_bits > REQ_W'(MAX_BITS)) ? CNT_W'(MAX_BITS) : CNT_W'(req_bits);

  ecr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (rx_level),
    .level  (lvl_sync),
    .toggle (edge_seen)
  );

  ecr_tick_timer #(.TURN_TICKS(TURN_TICKS), .WIN_TICKS(WIN_TICKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start),
    .run     (phase_q != PH_IDLE),
    .tick_en (tick_en),
    .in_bits (phase_q == PH_BITS),
    .wrap    (wrap)
  );

  assign win_close = wrap && (phase_q == PH_BITS);

  ecr_edge_win #(.EDGE_LO(EDGE_LO), .EDGE_HI(EDGE_HI)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start),
    .count_en (phase_q == PH_BITS),
    .toggle   (edge_seen),
    .close    (win_close),
    .bit_val  (bit_val)
  );

  assign last_bit = ((CNT_W'(idx_q) + 1'b1) == need_q);

  always_comb begin
    word_now        = shreg_q;
    word_now[idx_q] = bit_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      idx_q    <= '0;
      need_q   <= '0;
      shreg_q  <= '0;
      rx_data  <= '0;
      rx_nbits <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rx_data  <= '0;
        rx_nbits <= req_len;
        shreg_q  <= '0;
        idx_q    <= '0;
        need_q   <= req_len;
        if (req_len == '0) begin
          phase_q <= PH_IDLE;
          done    <= 1'b1;
        end else begin
          phase_q <= PH_TURN;
        end
      end else begin
        unique case (phase_q)
          PH_TURN: begin
            if (wrap) phase_q <= PH_BITS;
          end
          PH_BITS: begin
            if (win_close) begin
              shreg_q <= word_now;
              if (last_bit) begin
                rx_data <= word_now;
                done    <= 1'b1;
                phase_q <= PH_IDLE;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  logic unused_lvl;
  assign unused_lvl = lvl_sync;
endmodule

// File: rtl/ecr_checker.sv
module ecr_checker #(
  parameter int MAX_BITS = 16,
  parameter int REQ_W    = 6,
  parameter int CNT_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [REQ_W-1:0]    req_bits,
  input logic [MAX_BITS-1:0] rx_data,
  input logic [CNT_W-1:0]    rx_nbits,
  input logic                done,
  input ecr_pkg::rx_phase_e  phase_q
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ecr_pkg::PH_IDLE && !start) |=> ($stable(rx_data) && $stable(rx_nbits)));

  // R5
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rx_nbits) <= MAX_BITS);

  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((rx_data >> rx_nbits) == '0));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && req_bits != '0) |=> !done);

  // R6
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && req_bits == '0) |=> (done && rx_nbits == '0 && rx_data == '0));
endmodule

bind edge_count_rx ecr_checker #(
  .MAX_BITS (MAX_BITS),
  .REQ_W    (REQ_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .req_bits (req_bits),
  .rx_data  (rx_data),
  .rx_nbits (rx_nbits),
  .done     (done),
  .phase_q  (phase_q)
);

// File: tb/sim_edge_count_rx.sv
module sim_edge_count_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic        rx_level = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  req_bits = '0;
  logic [15:0] rx_data;
  logic [4:0]  rx_nbits;
  logic        done;

  always #2 clk = ~clk;

  edge_count_rx u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rx_level(rx_level),
    .start(start), .req_bits(req_bits), .rx_data(rx_data),
    .rx_nbits(rx_nbits), .done(done)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [15:0] data;
    logic [4:0]  nbits;
    int unsigned at;
  } exp_t;
  exp_t sb[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per done strobe
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R8", "done with nothing pending", 1, 0);
        end else begin
          e = sb.pop_front();
          check(rx_data == e.data, "R3/R4", "rx_data", rx_data, e.data);
          check(rx_nbits == e.nbits, "R5", "rx_nbits", rx_nbits, e.nbits);
          check(cyc == e.at, "R2", "done cycle", cyc, e.at);
        end
      end
      if (done && prev_done) check(1'b0, "R7", "done wider than one cycle", 1, 0);
      prev_done <= done;
    end
  end

  task automatic run_frame(input int req, input int cnt[16], input int div);
    int n;
    logic [15:0] d;
    exp_t e;
    int lim;
    n = (req > 16) ? 16 : req;
    d = '0;
    for (int i = 0; i < n; i++) if (cnt[i] > 20 && cnt[i] < 60) d[i] = 1'b1;
    @(negedge clk);
    e.data  = d;
    e.nbits = 5'(n);
    e.at    = cyc + 1 + ((n == 0) ? 0 : div * (490 + 150 * n));
    sb.push_back(e);
    start    = 1'b1;
    req_bits = 6'(req);
    tick_en  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lim = (n == 0) ? 3 : div * (490 + 150 * n) + 4;
    for (int c = 1; c <= lim; c++) begin
      tick_en = ((c % div) == 0);
      for (int i = 0; i < n; i++) begin
        int base;
        base = div * (490 + 150 * i) + 10 * div;
        if (c >= base && c < base + cnt[i]) rx_level = ~rx_level;
      end
      @(negedge clk);
    end
    tick_en = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int cnt[16];
    logic [15:0] d0;
    logic [4:0]  n0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1", "done after reset", done, 0);
    check(rx_data == '0, "R1", "rx_data after reset", rx_data, 0);
    check(rx_nbits == '0, "R1", "rx_nbits after reset", rx_nbits, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4 LSB-first alternating pattern, 7 bits -> 0x55
    cnt = '{42, 0, 42, 0, 42, 0, 42, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_frame(7, cnt, 1);

    // R3 thresholds: 20,21,59,60,0,1,42,61,130,22,58,19,40,41,0,50
    cnt = '{20, 21, 59, 60, 0, 1, 42, 61, 130, 22, 58, 19, 40, 41, 0, 50};
    run_frame(16, cnt, 1);

    // R2 slower tick rate (every second cycle), 6 bits -> 0x3b
    cnt = '{42, 42, 0, 42, 42, 42, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_frame(6, cnt, 2);

    // R5 requested 20 bits, limited to 16
    cnt = '{30, 0, 0, 45, 45, 0, 30, 30, 0, 0, 55, 0, 42, 42, 42, 25};
    run_frame(20, cnt, 1);

    // R6 zero length
    run_frame(0, cnt, 1);

    // R8 restart during turnaround: abandoned reply never reports
    @(negedge clk);
    start = 1'b1;
    req_bits = 6'd4;
    @(negedge clk);
    start = 1'b0;
    repeat (200) @(negedge clk);
    cnt = '{50, 0, 25, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    run_frame(3, cnt, 1);

    // R7 result held and rx_level ignored while idle
    d0 = rx_data;
    n0 = rx_nbits;
    repeat (300) begin
      rx_level = ~rx_level;
      @(negedge clk);
    end
    check(rx_data == d0, "R7", "rx_data held while idle", rx_data, d0);
    check(rx_nbits == n0, "R7", "rx_nbits held while idle", rx_nbits, n0);

    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R2", "expected done never seen", sb.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule